// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

This block is a 32-bit free-running timer that a processor controls through a small word-indexed register bus with one-cycle write and read strobes. Software selects whether the count rises or falls, picks a prescale exponent so the count moves once every 2^N clock cycles, and starts or stops the timer by writing command bits. The count can be loaded or read at any moment.

When a rising count passes the all-ones value, or a falling count passes zero, the counter wraps and keeps going, and a sticky flag records the event. Flags are raised or lowered by software through separate write-one-to-set and write-one-to-clear registers. A mask register selects which flags drive the single interrupt line. A typical use is to load a count, pick a direction and a prescale, unmask the wrap flag and start, and then service the interrupt.

Top module: `ptimer_top`

## Requirements
- R1: After reset the count, configuration, mask and flags all read 0, the counter is stopped in rising mode with exponent 0, and `irq` is low.
- R2: Registers are selected by the word index `addr`: 0 configuration (mode in bits [1:0], exponent in bits [31:24], other bits read 0), 1 command, 3 interrupt mask (2 bits), 4 flags (2 bits, writes ignored), 5 flag set, 6 flag clear, 9 count. A read of indexes 1, 5, 6 or any unmapped index returns 0. Read data appears on `rdata` at the clock edge that samples `rd_en`.
- R3: With mode 0 and the counter running, the count rises by 1 on each prescaled tick.
- R4: With mode 1 and the counter running, the count falls by 1 on each prescaled tick.
- R5: With exponent N the count moves once every 2^N clock cycles, the first move coming 2^N cycles after the start write; an exponent above 15 behaves as 15.
- R6: A command write with bit 0 set starts the counter and one with bit 1 set stops it; with both bits set it starts. A stopped counter holds its value.
- R7: A rising count at 0xFFFFFFFF wraps to 0 on the next tick, sets flag bit 0 and keeps running.
- R8: A falling count at 0 wraps to 0xFFFFFFFF on the next tick, sets flag bit 1 and keeps running.
- R9: A write to the flag-set register ORs the written bits into the flags; a write to the flag-clear register clears the flags written as 1; flags stay set otherwise.
- R10: `irq` is high exactly when some flag bit and its mask bit are both 1, updated in the cycle after the write or event.
- R11: A count write loads the written value, and wins over a tick in the same cycle.
- R12: When a wrap event and a software clear of the same flag coincide, the flag ends up set.
- R13: An accepted start restarts the prescaler, so the next tick comes a full 2^N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can hit the same cycle: a counter wrap raising a flag while software writes a clear to that flag, and a tick while software loads the count. The bench arranges each by loading the count one or two steps short of the wrap or starting the counter, then timing the clear or load write so its capturing edge is the very edge of the wrap or tick. It judges the flag by reading it back after stopping the counter (it must remain set), and the load by stopping one tick later and reading the loaded value plus one.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_RSV2 = 2'd2,
        DIR_RSV3 = 2'd3
    } dir_e;

    localparam int IDX_CFG  = 0;
    localparam int IDX_CMD  = 1;
    localparam int IDX_MASK = 3;
    localparam int IDX_FLAG = 4;
    localparam int IDX_FSET = 5;
    localparam int IDX_FCLR = 6;
    localparam int IDX_CNT  = 9;

    localparam int FLAG_N   = 2;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_UNF = 1;

    localparam int CMD_GO   = 0;
    localparam int CMD_HALT = 1;

    typedef struct packed {
        logic [7:0] exp;
        dir_e       mode;
    } cfg_t;

    typedef struct packed {
        logic cfg;
        logic cmd;
        logic mask;
        logic fset;
        logic fclr;
        logic cnt;
    } wsel_t;

    function automatic wsel_t decode_write(input logic en, input int idx);
        wsel_t s;
        s      = '0;
        s.cfg  = en && (idx == IDX_CFG);
        s.cmd  = en && (idx == IDX_CMD);
        s.mask = en && (idx == IDX_MASK);
        s.fset = en && (idx == IDX_FSET);
        s.fclr = en && (idx == IDX_FCLR);
        s.cnt  = en && (idx == IDX_CNT);
        return s;
    endfunction

endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
    parameter int EXP_MAX = 15,
    localparam int EW = $clog2(EXP_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [7:0] exp_raw,
    output logic       tick
);
    logic [EXP_MAX-1:0] pre;
    logic [EXP_MAX-1:0] span;
    logic [EW-1:0]      exp_eff;

    always_comb begin
        if (exp_raw > 8'(EXP_MAX))
            exp_eff = EW'(EXP_MAX);
        else
            exp_eff = exp_raw[EW-1:0];
    end

    for (genvar i = 0; i < EXP_MAX; i++) begin : g_span
        assign span[i] = (EW'(i) < exp_eff);
    end

    assign tick = run && ((pre & span) == span);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre <= '0;
        else if (run)
            pre <= pre + 1'b1;
    end
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter
    import ptimer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  dir_e         dir,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         ovf_evt,
    output logic         unf_evt
);
    logic step;

    assign step    = tick && !load;
    assign ovf_evt = step && (dir == DIR_UP)   && (count == {W{1'b1}});
    assign unf_evt = step && (dir == DIR_DOWN) && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (step) begin
            case (dir)
                DIR_UP:   count <= count + 1'b1;
                DIR_DOWN: count <= count - 1'b1;
                default:  count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ptimer_flags.sv
module ptimer_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (hw_set[i])
                flags[i] <= 1'b1;
            else if (sw_clr[i])
                flags[i] <= 1'b0;
            else if (sw_set[i])
                flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int EXP_MAX = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int EXP_LSB = DATA_W - 8;

    wsel_t              ws;
    cfg_t               cfg;
    logic [FLAG_N-1:0]  mask;
    logic [FLAG_N-1:0]  flags;
    logic [FLAG_N-1:0]  fset_v;
    logic [FLAG_N-1:0]  fclr_v;
    logic [FLAG_N-1:0]  hw_v;
    logic               running;
    logic               go;
    logic               halt;
    logic               tick;
    logic               ovf_evt;
    logic               unf_evt;
    logic [DATA_W-1:0]  count;
    logic [DATA_W-1:0]  rd_mux;

    assign ws   = decode_write(wr_en, int'(addr));
    assign go   = ws.cmd && wdata[CMD_GO];
    assign halt = ws.cmd && wdata[CMD_HALT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{exp: 8'd0, mode: DIR_UP};
            mask    <= '0;
            running <= 1'b0;
        end else begin
            if (ws.cfg) begin
                cfg.exp  <= wdata[DATA_W-1:EXP_LSB];
                cfg.mode <= dir_e'(wdata[1:0]);
            end
            if (ws.mask)
                mask <= wdata[FLAG_N-1:0];
            if (go)
                running <= 1'b1;
            else if (halt)
                running <= 1'b0;
        end
    end

    ptimer_prescale #(.EXP_MAX(EXP_MAX)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (go),
        .exp_raw (cfg.exp),
        .tick    (tick)
    );

    ptimer_counter #(.W(DATA_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .dir      (cfg.mode),
        .load     (ws.cnt),
        .load_val (wdata),
        .count    (count),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt)
    );

    always_comb begin
        hw_v           = '0;
        hw_v[FLAG_OVF] = ovf_evt;
        hw_v[FLAG_UNF] = unf_evt;
        fset_v         = ws.fset ? wdata[FLAG_N-1:0] : '0;
        fclr_v         = ws.fclr ? wdata[FLAG_N-1:0] : '0;
    end

    ptimer_flags #(.N(FLAG_N)) i_flg (
        .clk    (clk),
        .rst    (rst),
        .sw_set (fset_v),
        .sw_clr (fclr_v),
        .hw_set (hw_v),
        .flags  (flags)
    );

    assign irq = |(flags & mask);

    always_comb begin
        rd_mux = '0;
        case (int'(addr))
            IDX_CFG: begin
                rd_mux[DATA_W-1:EXP_LSB] = cfg.exp;
                rd_mux[1:0]              = cfg.mode;
            end
            IDX_MASK: rd_mux[FLAG_N-1:0] = mask;
            IDX_FLAG: rd_mux[FLAG_N-1:0] = flags;
            IDX_CNT:  rd_mux             = count;
            default:  rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en)
            rdata <= '0;
        else
            rdata <= rd_mux;
    end
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker
    import ptimer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              running,
    input logic              tick,
    input logic              ovf_evt,
    input logic              unf_evt,
    input cfg_t              cfg,
    input wsel_t             ws,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] count,
    input logic [FLAG_N-1:0] flags
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq); // R1

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!running && !ws.cnt) |=> $stable(count)); // R6

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !ws.cnt && cfg.mode == DIR_UP) |=> count == $past(count) + 1'b1); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !ws.cnt && cfg.mode == DIR_DOWN) |=> count == $past(count) - 1'b1); // R4

    AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        tick |-> running); // R5

    AST_OVF_RAISES: assert property (@(posedge clk) disable iff (rst)
        (tick && !ws.cnt && cfg.mode == DIR_UP && count == {DATA_W{1'b1}})
        |=> (flags[FLAG_OVF] && count == '0)); // R7

    AST_UNF_RAISES: assert property (@(posedge clk) disable iff (rst)
        (tick && !ws.cnt && cfg.mode == DIR_DOWN && count == '0)
        |=> (flags[FLAG_UNF] && count == {DATA_W{1'b1}})); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[FLAG_OVF] && !(ws.fclr && wdata[FLAG_OVF])) |=> flags[FLAG_OVF]); // R9

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt || unf_evt) |=> (flags != '0)); // R12

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        ws.cnt |=> count == $past(wdata)); // R11
endmodule

bind ptimer_top ptimer_checker #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .running (running),
    .tick    (tick),
    .ovf_evt (ovf_evt),
    .unf_evt (unf_evt),
    .cfg     (cfg),
    .ws      (ws),
    .wdata   (wdata),
    .count   (count),
    .flags   (flags)
);

// File: tb/test_ptimer_top.sv
module test_ptimer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ptimer_top i_ptimer_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    localparam int A_CFG = 0, A_CMD = 1, A_MASK = 3, A_FLAG = 4;
    localparam int A_FSET = 5, A_FCLR = 6, A_CNT = 9;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input int idx, input logic [31:0] v);
        wr_en = 1'b1; addr = 4'(idx); wdata = v;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        rd_en = 1'b1; addr = 4'(idx);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] mode, input logic [7:0] e, input logic [31:0] c);
        wr(A_CMD, 32'h2);
        wr(A_CFG, {e, 22'd0, mode});
        wr(A_CNT, c);
        wr(A_FCLR, 32'h3);
    endtask

    // start, let w more cycles pass, stop (stop edge is w+1 edges after start edge)
    task automatic run_for(input int w);
        wr(A_CMD, 32'h1);
        idle(w);
        wr(A_CMD, 32'h2);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_CFG, v);  check("R1 cfg", v, 32'd0);
        rd(A_MASK, v); check("R1 mask", v, 32'd0);
        rd(A_FLAG, v); check("R1 flags", v, 32'd0);
        idle(10);
        rd(A_CNT, v);  check("R1 count stopped", v, 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_CFG, 32'h12345601);
        rd(A_CFG, v);  check("R2 cfg readback", v, 32'h12000001);
        wr(A_MASK, 32'hFFFFFFFF);
        rd(A_MASK, v); check("R2 mask readback", v, 32'h3);
        wr(A_MASK, 32'h0);
        wr(A_FLAG, 32'h3);
        rd(A_FLAG, v); check("R2 flags write ignored", v, 32'h0);
        rd(A_CMD, v);  check("R2 cmd reads 0", v, 32'h0);
        rd(A_FSET, v); check("R2 set reg reads 0", v, 32'h0);
        rd(A_FCLR, v); check("R2 clr reg reads 0", v, 32'h0);
        rd(2, v);      check("R2 unmapped 2", v, 32'h0);
        rd(15, v);     check("R2 unmapped 15", v, 32'h0);
        wr(A_CNT, 32'hCAFE0001);
        rd(A_CNT, v);  check("R2 count readback", v, 32'hCAFE0001);
    endtask

    task automatic t_up;
        logic [31:0] v;
        setup(2'd0, 8'd0, 32'd7);
        run_for(9);
        rd(A_CNT, v); check("R3 up N=0", v, 32'd17);
        setup(2'd0, 8'd2, 32'd0);
        run_for(9);
        rd(A_CNT, v); check("R5 up N=2", v, 32'd2);
    endtask

    task automatic t_down;
        logic [31:0] v;
        setup(2'd1, 8'd1, 32'd50);
        run_for(9);
        rd(A_CNT, v); check("R4 down N=1", v, 32'd45);
    endtask

    task automatic t_clamp;
        logic [31:0] v;
        setup(2'd0, 8'd20, 32'd0);
        run_for(32767);
        rd(A_CNT, v); check("R5 exponent clamp", v, 32'd1);
    endtask

    task automatic t_startstop;
        logic [31:0] v;
        logic [31:0] v2;
        setup(2'd0, 8'd0, 32'd0);
        wr(A_CMD, 32'h3);
        idle(4);
        wr(A_CMD, 32'h2);
        rd(A_CNT, v); check("R6 start wins", v, 32'd5);
        idle(10);
        rd(A_CNT, v2); check("R6 stopped holds", v2, v);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        setup(2'd0, 8'd0, 32'hFFFFFFFD);
        run_for(4);
        rd(A_CNT, v);  check("R7 wrap and continue", v, 32'd2);
        rd(A_FLAG, v); check("R7 overflow flag", v, 32'h1);
    endtask

    task automatic t_underflow;
        logic [31:0] v;
        setup(2'd1, 8'd0, 32'd1);
        run_for(4);
        rd(A_CNT, v);  check("R8 wrap and continue", v, 32'hFFFFFFFC);
        rd(A_FLAG, v); check("R8 underflow flag", v, 32'h2);
    endtask

    task automatic t_flags_sw;
        logic [31:0] v;
        wr(A_FCLR, 32'h3);
        wr(A_FSET, 32'h2);
        rd(A_FLAG, v); check("R9 set bit1", v, 32'h2);
        wr(A_FSET, 32'h1);
        rd(A_FLAG, v); check("R9 set ORs", v, 32'h3);
        wr(A_FCLR, 32'h2);
        rd(A_FLAG, v); check("R9 clear bit1", v, 32'h1);
        idle(5);
        rd(A_FLAG, v); check("R9 sticky", v, 32'h1);
        wr(A_FCLR, 32'h1);
        rd(A_FLAG, v); check("R9 clear bit0", v, 32'h0);
    endtask

    task automatic t_irq;
        wr(A_FCLR, 32'h3);
        wr(A_MASK, 32'h1);
        check("R10 masked on, no flag", {31'd0, irq}, 32'd0);
        wr(A_FSET, 32'h1);
        check("R10 flag and mask", {31'd0, irq}, 32'd1);
        wr(A_MASK, 32'h2);
        check("R10 other mask bit", {31'd0, irq}, 32'd0);
        wr(A_FSET, 32'h2);
        check("R10 second bit", {31'd0, irq}, 32'd1);
        wr(A_FCLR, 32'h2);
        check("R10 cleared", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h0);
        wr(A_FCLR, 32'h3);
    endtask

    task automatic t_load;
        logic [31:0] v;
        setup(2'd0, 8'd0, 32'd0);
        wr(A_CMD, 32'h1);
        idle(3);
        wr(A_CNT, 32'd100);
        wr(A_CMD, 32'h2);
        rd(A_CNT, v); check("R11 load beats tick", v, 32'd101);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        setup(2'd0, 8'd0, 32'hFFFFFFFE);
        wr(A_CMD, 32'h1);
        idle(1);
        wr(A_FCLR, 32'h1);
        wr(A_CMD, 32'h2);
        rd(A_FLAG, v); check("R12 event beats clear", v, 32'h1);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        setup(2'd0, 8'd2, 32'd0);
        wr(A_CMD, 32'h1);
        idle(1);
        wr(A_CMD, 32'h1);
        idle(2);
        wr(A_CMD, 32'h2);
        rd(A_CNT, v); check("R13 prescaler restart", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_up();
        t_down();
        t_clamp();
        t_startstop();
        t_overflow();
        t_underflow();
        t_flags_sw();
        t_irq();
        t_load();
        t_collision();
        t_restart();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule